// File: doc/BRIEF.md
# Two-Way Instruction Cache with Sequential Line Prefetch

This block sits between an instruction fetch unit and a line-wide memory port. The fetch unit presents half-line addresses; a hit answers the next cycle with one aligned half of a cached line. Lines are held in a two-way set-associative array, and one replacement bit per set picks the victim.

A miss stalls the fetch side. The block asks memory for the aligned line that holds the address, installs it, and answers from the returning data. It then requests the following sequential line as a prefetch, unless that line is already resident or the missed line is the last one in the address space. While that prefetch is in flight the fetch side is open again. Hits are answered at full rate. A miss taken during that window waits for the prefetch to land and is then looked up again, so it is served without a memory request when it falls inside the prefetched line.

A flush input invalidates every line at once. Every width and the set count are parameters; the default geometry is four sets of two 64-byte lines over a 16-bit byte address space.

Top module: `icache_nlp`

## Requirements
- R1: After reset no line is valid, `fetch_ready` is 1, `rsp_valid` is 0 and `mem_req` is 0.
- R2: A fetch accepted (`fetch_req` and `fetch_ready` high at a clock edge) that hits gives `rsp_valid` high for exactly one cycle right after that edge. `fetch_haddr` is the byte address shifted right by log2(LINE_BYTES/2). Its bit 0 selects the upper (1) or lower (0) half of the line. Byte k of a line sits at bits [8k+7:8k] of `mem_rdata`, and byte k of the chosen half sits at bits [8k+7:8k] of `rsp_data`.
- R3: An accepted miss drops `fetch_ready`. The block requests the line whose address is `fetch_haddr` without its bit 0. It answers with the selected half of the returned data in the cycle after `mem_rvalid`.
- R4: When a demand fill completes, line+1 is requested as a prefetch and installed, unless line+1 is already valid in the cache.
- R5: No prefetch is requested when the demand line address is all ones.
- R6: While a prefetch is outstanding, fetches are accepted and hits answer one cycle later. The first miss in that window closes `fetch_ready`. It is looked up again once the prefetch is installed, and it makes no memory request if it lies in the prefetched line.
- R7: An install goes to way 0 if it is invalid, else to way 1 if it is invalid, else to the least recently used way. A hit or an install marks its way as most recently used.
- R8: A one-cycle `flush` pulse invalidates all lines, so every later fetch misses until refilled.
- R9: `mem_req` stays high with a stable `mem_line` until `mem_gnt`, and no new request starts before the outstanding line has returned.
- R10: A line is never resident in both ways of a set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all lines |
| fetch_req | input | 1 | Fetch request |
| fetch_haddr | input | ADDR_W-log2(LINE_BYTES)+1 | Half-line fetch address |
| fetch_ready | output | 1 | Fetch can be accepted this cycle |
| rsp_valid | output | 1 | Fetch data valid |
| rsp_data | output | LINE_BYTES*4 | Half-line of instruction bytes |
| mem_req | output | 1 | Line fill request |
| mem_line | output | ADDR_W-log2(LINE_BYTES) | Line address of the fill |
| mem_gnt | input | 1 | Fill request accepted |
| mem_rvalid | input | 1 | Fill data valid |
| mem_rdata | input | LINE_BYTES*8 | Whole-line fill data |

## Verification
On every cycle the embedded properties check the following. Ways of a set never match the same tag. A flush leaves no valid bit. A hit moves the replacement bit to the other way. A pending fill request holds its line until granted. An accepted hit is answered in the next cycle. A demand miss closes the fetch port. The last line of the address space goes straight back to idle. The choice of victim over a history of accesses, the data returned for each half, and the prefetch being skipped when its line is resident can only be seen through the bench's scenarios. The same goes for a miss queued behind a prefetch being served from the prefetched line.

// File: rtl/icache_pkg.sv
package icache_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DM_REQ,
      ST_DM_WAIT,
      ST_PF_REQ,
      ST_PF_WAIT,
      ST_RECHECK
   } ic_state_e;

endpackage

// File: rtl/icache_tags.sv
module icache_tags #(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 2,
   parameter int LADDR_W  = 10,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int TAG_W   = LADDR_W - SET_W
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic [LADDR_W-1:0] a_line,
   output logic               a_hit,
   output logic               a_way,
   input  logic               touch_en,
   input  logic [LADDR_W-1:0] b_line,
   output logic               b_hit,
   input  logic               fill_en,
   input  logic [LADDR_W-1:0] fill_line,
   output logic               fill_way
);

   logic [NUM_SETS-1:0][NUM_WAYS-1:0] valid_q;
   logic [TAG_W-1:0]                  tag_q [NUM_SETS][NUM_WAYS];
   logic [NUM_SETS-1:0]               lru_q;

   logic [SET_W-1:0] a_set, b_set, f_set;
   logic [TAG_W-1:0] a_tag, b_tag, f_tag;
   logic [NUM_WAYS-1:0] a_match, b_match;

   assign a_set = a_line[SET_W-1:0];
   assign a_tag = a_line[LADDR_W-1:SET_W];
   assign b_set = b_line[SET_W-1:0];
   assign b_tag = b_line[LADDR_W-1:SET_W];
   assign f_set = fill_line[SET_W-1:0];
   assign f_tag = fill_line[LADDR_W-1:SET_W];

   generate
      for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
         assign a_match[w] = valid_q[a_set][w] && (tag_q[a_set][w] == a_tag);
         assign b_match[w] = valid_q[b_set][w] && (tag_q[b_set][w] == b_tag);
      end
   endgenerate

   assign a_hit = |a_match;
   assign a_way = a_match[1];
   assign b_hit = |b_match;

   // victim: first invalid way, else the way the set bit points at
   always_comb begin
      if (!valid_q[f_set][0])      fill_way = 1'b0;
      else if (!valid_q[f_set][1]) fill_way = 1'b1;
      else                         fill_way = lru_q[f_set];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= '0;
         lru_q   <= '0;
      end else begin
         if (flush) begin
            valid_q <= '0;
            lru_q   <= '0;
         end
         if (touch_en) lru_q[a_set] <= ~a_way;
         if (fill_en) begin
            valid_q[f_set][fill_way] <= 1'b1;
            lru_q[f_set]             <= ~fill_way;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (fill_en) tag_q[f_set][fill_way] <= f_tag;
   end

   // R10: a looked-up line matches at most one way
   p_single_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(a_match) && $onehot0(b_match))
      else $error("line resident in two ways");

   // R8: flush without a fill leaves nothing valid
   p_flush_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (flush && !fill_en) |=> (valid_q == '0))
      else $error("valid bit survived flush");

   // R7: a hit makes the other way the next victim
   p_touch_lru_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && !fill_en) |=> (lru_q[$past(a_set)] == ~$past(a_way)))
      else $error("replacement bit not updated on hit");

endmodule

// File: rtl/icache_data.sv
module icache_data #(
   parameter int NUM_SETS = 4,
   parameter int NUM_WAYS = 2,
   parameter int LINE_W   = 512,
   localparam int SET_W   = $clog2(NUM_SETS),
   localparam int HALF_W  = LINE_W / 2
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [SET_W-1:0]  wr_set,
   input  logic              wr_way,
   input  logic [LINE_W-1:0] wr_data,
   input  logic [SET_W-1:0]  rd_set,
   input  logic              rd_way,
   input  logic              rd_half,
   output logic [HALF_W-1:0] rd_data
);

   logic [LINE_W-1:0] line_q [NUM_SETS][NUM_WAYS];
   logic [LINE_W-1:0] line_sel;

   always_ff @(posedge clk) begin
      if (wr_en) line_q[wr_set][wr_way] <= wr_data;
   end

   assign line_sel = line_q[rd_set][rd_way];
   assign rd_data  = rd_half ? line_sel[LINE_W-1:HALF_W] : line_sel[HALF_W-1:0];

endmodule

// File: rtl/icache_ctrl.sv
module icache_ctrl
   import icache_pkg::*;
#(
   parameter int LADDR_W  = 10,
   localparam int HADDR_W = LADDR_W + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               fetch_req,
   input  logic [HADDR_W-1:0] fetch_haddr,
   output logic               fetch_ready,
   output logic [LADDR_W-1:0] look_line,
   output logic               look_half,
   input  logic               look_hit,
   output logic               touch_en,
   output logic [LADDR_W-1:0] next_line,
   input  logic               next_hit,
   output logic               fill_en,
   output logic [LADDR_W-1:0] fill_line,
   output logic               rsp_from_fill,
   output logic               fill_half,
   output logic               mem_req,
   output logic [LADDR_W-1:0] mem_line,
   input  logic               mem_gnt,
   input  logic               mem_rvalid
);

   ic_state_e          st_q, st_d;
   logic [HADDR_W-1:0] pend_q, pend_d;
   logic [LADDR_W-1:0] pf_q, pf_d;
   logic               pm_q, pm_d;

   logic [LADDR_W-1:0] pend_line;
   logic [HADDR_W-1:0] look_h;
   logic in_pf, accept, miss_acc, last_line, dm_fill, pf_fill;

   assign pend_line   = pend_q[HADDR_W-1:1];
   assign in_pf       = (st_q == ST_PF_REQ) || (st_q == ST_PF_WAIT);
   assign fetch_ready = (st_q == ST_IDLE) || (in_pf && !pm_q);
   assign accept      = fetch_req && fetch_ready;

   assign look_h    = (st_q == ST_RECHECK) ? pend_q : fetch_haddr;
   assign look_line = look_h[HADDR_W-1:1];
   assign look_half = look_h[0];
   assign touch_en  = (accept || (st_q == ST_RECHECK)) && look_hit;
   assign miss_acc  = accept && !look_hit;

   assign next_line = pend_line + {{(LADDR_W-1){1'b0}}, 1'b1};
   assign last_line = &pend_line;

   assign mem_req  = (st_q == ST_DM_REQ) || (st_q == ST_PF_REQ);
   assign mem_line = (st_q == ST_PF_REQ) ? pf_q : pend_line;

   assign dm_fill       = mem_rvalid && (st_q == ST_DM_WAIT);
   assign pf_fill       = mem_rvalid && (st_q == ST_PF_WAIT);
   assign fill_en       = dm_fill || pf_fill;
   assign fill_line     = pf_fill ? pf_q : pend_line;
   assign rsp_from_fill = dm_fill;
   assign fill_half     = pend_q[0];

   always_comb begin
      st_d   = st_q;
      pend_d = pend_q;
      pf_d   = pf_q;
      pm_d   = pm_q;
      case (st_q)
         ST_IDLE: begin
            if (miss_acc) begin
               pend_d = fetch_haddr;
               st_d   = ST_DM_REQ;
            end
         end
         ST_DM_REQ: begin
            if (mem_gnt) st_d = ST_DM_WAIT;
         end
         ST_DM_WAIT: begin
            if (mem_rvalid) begin
               if (last_line || next_hit) begin
                  st_d = ST_IDLE;
               end else begin
                  pf_d = next_line;
                  st_d = ST_PF_REQ;
               end
            end
         end
         ST_PF_REQ, ST_PF_WAIT: begin
            if (miss_acc) begin
               pend_d = fetch_haddr;
               pm_d   = 1'b1;
            end
            if ((st_q == ST_PF_REQ) && mem_gnt) st_d = ST_PF_WAIT;
            if (pf_fill) begin
               pm_d = 1'b0;
               st_d = (pm_q || miss_acc) ? ST_RECHECK : ST_IDLE;
            end
         end
         ST_RECHECK: begin
            st_d = look_hit ? ST_IDLE : ST_DM_REQ;
         end
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         pend_q <= '0;
         pf_q   <= '0;
         pm_q   <= 1'b0;
      end else begin
         st_q   <= st_d;
         pend_q <= pend_d;
         pf_q   <= pf_d;
         pm_q   <= pm_d;
      end
   end

   // R9: an ungranted request holds its line
   p_req_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_gnt) |=> (mem_req && $stable(mem_line)))
      else $error("fill request dropped or changed before grant");

   // R5: the top line of the address space never triggers a prefetch
   p_top_no_pf_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_fill && last_line) |=> (st_q == ST_IDLE))
      else $error("prefetch past top of address space");

   // R3: a demand miss closes the fetch port
   p_miss_stalls_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (miss_acc && (st_q == ST_IDLE)) |=> !fetch_ready)
      else $error("fetch port open during demand miss");

   // R4 / R6: a needed prefetch is requested and the port reopens
   p_pf_opens_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (dm_fill && !last_line && !next_hit) |=> (fetch_ready && mem_req))
      else $error("prefetch not issued or port still closed");

endmodule

// File: rtl/icache_nlp.sv
module icache_nlp #(
   parameter int ADDR_W     = 16,
   parameter int LINE_BYTES = 64,
   parameter int NUM_SETS   = 4,
   parameter int NUM_WAYS   = 2,
   localparam int OFF_W     = $clog2(LINE_BYTES),
   localparam int SET_W     = $clog2(NUM_SETS),
   localparam int LADDR_W   = ADDR_W - OFF_W,
   localparam int HADDR_W   = LADDR_W + 1,
   localparam int LINE_W    = LINE_BYTES * 8,
   localparam int HALF_W    = LINE_W / 2
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               flush,
   input  logic               fetch_req,
   input  logic [HADDR_W-1:0] fetch_haddr,
   output logic               fetch_ready,
   output logic               rsp_valid,
   output logic [HALF_W-1:0]  rsp_data,
   output logic               mem_req,
   output logic [LADDR_W-1:0] mem_line,
   input  logic               mem_gnt,
   input  logic               mem_rvalid,
   input  logic [LINE_W-1:0]  mem_rdata
);

   generate
      if (NUM_WAYS != 2) begin : g_bad_ways
         $error("icache_nlp: one replacement bit per set needs NUM_WAYS == 2");
      end
      if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
         $error("icache_nlp: NUM_SETS must be a power of two, at least 2");
      end
      if (LINE_BYTES < 2 || (LINE_BYTES & (LINE_BYTES - 1)) != 0) begin : g_bad_line
         $error("icache_nlp: LINE_BYTES must be a power of two, at least 2");
      end
      if (ADDR_W <= OFF_W + SET_W) begin : g_bad_addr
         $error("icache_nlp: ADDR_W leaves no tag bits");
      end
   endgenerate

   logic [LADDR_W-1:0] look_line, next_line, fill_line;
   logic look_half, look_hit, look_way, touch_en;
   logic next_hit, fill_en, fill_way, rsp_from_fill, fill_half;
   logic [HALF_W-1:0] rd_data, fill_sel;

   icache_ctrl #(.LADDR_W(LADDR_W)) u_ctrl (
      .clk          (clk),
      .rst_n        (rst_n),
      .fetch_req    (fetch_req),
      .fetch_haddr  (fetch_haddr),
      .fetch_ready  (fetch_ready),
      .look_line    (look_line),
      .look_half    (look_half),
      .look_hit     (look_hit),
      .touch_en     (touch_en),
      .next_line    (next_line),
      .next_hit     (next_hit),
      .fill_en      (fill_en),
      .fill_line    (fill_line),
      .rsp_from_fill(rsp_from_fill),
      .fill_half    (fill_half),
      .mem_req      (mem_req),
      .mem_line     (mem_line),
      .mem_gnt      (mem_gnt),
      .mem_rvalid   (mem_rvalid)
   );

   icache_tags #(
      .NUM_SETS(NUM_SETS),
      .NUM_WAYS(NUM_WAYS),
      .LADDR_W (LADDR_W)
   ) u_tags (
      .clk      (clk),
      .rst_n    (rst_n),
      .flush    (flush),
      .a_line   (look_line),
      .a_hit    (look_hit),
      .a_way    (look_way),
      .touch_en (touch_en),
      .b_line   (next_line),
      .b_hit    (next_hit),
      .fill_en  (fill_en),
      .fill_line(fill_line),
      .fill_way (fill_way)
   );

   icache_data #(
      .NUM_SETS(NUM_SETS),
      .NUM_WAYS(NUM_WAYS),
      .LINE_W  (LINE_W)
   ) u_data (
      .clk    (clk),
      .wr_en  (fill_en),
      .wr_set (fill_line[SET_W-1:0]),
      .wr_way (fill_way),
      .wr_data(mem_rdata),
      .rd_set (look_line[SET_W-1:0]),
      .rd_way (look_way),
      .rd_half(look_half),
      .rd_data(rd_data)
   );

   assign fill_sel = fill_half ? mem_rdata[LINE_W-1:HALF_W] : mem_rdata[HALF_W-1:0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else begin
         rsp_valid <= touch_en || rsp_from_fill;
         if (rsp_from_fill)  rsp_data <= fill_sel;
         else if (touch_en)  rsp_data <= rd_data;
      end
   end

   // R2: an accepted hit is answered on the next cycle
   p_hit_answer_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (fetch_req && fetch_ready && look_hit) |=> rsp_valid)
      else $error("hit not answered in one cycle");

endmodule

// File: tb/icache_nlp_test.sv
module icache_nlp_test;

   localparam int ADDR_W  = 16;
   localparam int LBYTES  = 64;
   localparam int NS      = 4;
   localparam int LADDR_W = 10;
   localparam int HADDR_W = 11;
   localparam int LINE_W  = 512;
   localparam int HALF_W  = 256;
   localparam int LAT     = 12;
   localparam int TOPLINE = 1023;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic flush = 1'b0;
   logic fetch_req = 1'b0;
   logic [HADDR_W-1:0] fetch_haddr = '0;
   logic fetch_ready, rsp_valid, mem_req;
   logic [HALF_W-1:0] rsp_data;
   logic [LADDR_W-1:0] mem_line;
   logic mem_gnt = 1'b0;
   logic mem_rvalid = 1'b0;
   logic [LINE_W-1:0] mem_rdata = '0;

   int total = 0;
   int bad = 0;
   int cyc = 0;
   int n_fetch = 0;
   int rsp_seen = 0;
   int wait_cnt = 0;
   int hold_cnt = 0;
   int cur_line = 0;
   logic [LADDR_W-1:0] held_line = '0;
   int exp_q[$];

   // reference cache contents
   bit m_valid [NS][2];
   int m_tag   [NS][2];
   bit m_lru   [NS];

   always #4 clk = ~clk;

   icache_nlp uut (
      .clk(clk), .rst_n(rst_n), .flush(flush),
      .fetch_req(fetch_req), .fetch_haddr(fetch_haddr), .fetch_ready(fetch_ready),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_req(mem_req), .mem_line(mem_line), .mem_gnt(mem_gnt),
      .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
   );

   function automatic logic [LINE_W-1:0] line_bytes(input int line);
      logic [LINE_W-1:0] v;
      for (int b = 0; b < LBYTES; b++) v[8*b +: 8] = 8'(line * 7 + b * 13 + 5);
      return v;
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [HALF_W-1:0] act, input logic [HALF_W-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int m_find(input int line);
      int s = line % NS;
      for (int w = 0; w < 2; w++)
         if (m_valid[s][w] && m_tag[s][w] == line / NS) return w;
      return -1;
   endfunction

   function automatic void m_install(input int line);
      int s = line % NS;
      int v = !m_valid[s][0] ? 0 : (!m_valid[s][1] ? 1 : int'(m_lru[s]));
      m_valid[s][v] = 1'b1;
      m_tag[s][v]   = line / NS;
      m_lru[s]      = (v == 0);
   endfunction

   // applies one fetch to the reference; returns 1 on hit
   function automatic bit m_access(input int line);
      int w = m_find(line);
      if (w >= 0) begin
         m_lru[line % NS] = (w == 0);
         return 1'b1;
      end
      exp_q.push_back(line);
      m_install(line);
      if (line != TOPLINE && m_find(line + 1) < 0) begin
         exp_q.push_back(line + 1);
         m_install(line + 1);
      end
      return 1'b0;
   endfunction

   // memory model: grants after a short hold, returns data LAT cycles later
   initial begin
      forever begin
         @(negedge clk);
         mem_gnt    = 1'b0;
         mem_rvalid = 1'b0;
         if (wait_cnt > 0) begin
            wait_cnt--;
            if (wait_cnt == 0) begin
               mem_rvalid = 1'b1;
               mem_rdata  = line_bytes(cur_line);
            end
         end else if (rst_n && mem_req) begin
            hold_cnt++;
            if (hold_cnt == 1) held_line = mem_line;
            else check(mem_line == held_line, "R9", "line changed while waiting",
                       HALF_W'(mem_line), HALF_W'(held_line));
            if (hold_cnt == 3) begin
               hold_cnt = 0;
               if (exp_q.size() == 0) begin
                  check(1'b0, "R4", "unexpected fill request", HALF_W'(mem_line), '0);
               end else begin
                  check(int'(mem_line) == exp_q[0], "R3", "fill line order",
                        HALF_W'(mem_line), HALF_W'(exp_q[0]));
                  void'(exp_q.pop_front());
               end
               cur_line = int'(mem_line);
               mem_gnt  = 1'b1;
               wait_cnt = LAT;
            end
         end
      end
   end

   always @(negedge clk) if (rst_n && rsp_valid) rsp_seen++;

   task automatic do_fetch(input int baddr, input string req, input bit chk_lat);
      int line = baddr / LBYTES;
      int half = (baddr / (LBYTES / 2)) % 2;
      int lat = 1;
      bit hit;
      logic [LINE_W-1:0] full = line_bytes(line);
      logic [HALF_W-1:0] exp = half ? full[LINE_W-1:HALF_W] : full[HALF_W-1:0];
      @(negedge clk);
      while (!fetch_ready) @(negedge clk);
      hit = m_access(line);
      fetch_req   = 1'b1;
      fetch_haddr = HADDR_W'(baddr / (LBYTES / 2));
      n_fetch++;
      @(negedge clk);
      fetch_req = 1'b0;
      while (!rsp_valid && lat < 400) begin
         @(negedge clk);
         lat++;
      end
      check(rsp_valid && rsp_data == exp, req, "fetch data", rsp_data, exp);
      if (chk_lat) begin
         if (hit) check(lat == 1, req, "hit latency", HALF_W'(lat), HALF_W'(1));
         else     check(lat > 1, req, "miss answered too early", HALF_W'(lat), HALF_W'(2));
      end
   endtask

   task automatic wait_idle();
      int n = 0;
      @(negedge clk);
      while ((exp_q.size() != 0 || wait_cnt != 0 || mem_rvalid || !fetch_ready) && n < 2000) begin
         @(negedge clk);
         n++;
      end
      repeat (3) @(negedge clk);
   endtask

   task automatic do_flush();
      @(negedge clk);
      flush = 1'b1;
      @(negedge clk);
      flush = 1'b0;
      for (int s = 0; s < NS; s++) begin
         m_valid[s][0] = 1'b0;
         m_valid[s][1] = 1'b0;
         m_lru[s]      = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000) begin
         check(1'b0, "R1", "watchdog expired", '0, '0);
         finish_run();
      end
   end

   initial begin
      for (int s = 0; s < NS; s++) begin
         m_valid[s][0] = 1'b0;
         m_valid[s][1] = 1'b0;
         m_lru[s]      = 1'b0;
      end
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check(fetch_ready == 1'b1, "R1", "fetch_ready after reset", HALF_W'(fetch_ready), HALF_W'(1));
      check(rsp_valid == 1'b0, "R1", "rsp_valid after reset", HALF_W'(rsp_valid), '0);
      check(mem_req == 1'b0, "R1", "mem_req after reset", HALF_W'(mem_req), '0);

      // R3 demand miss, R6 hit while the prefetch is in flight
      do_fetch(16'h0000, "R3", 1'b1);
      do_fetch(16'h0020, "R6", 1'b1);
      wait_idle();
      // R4 prefetched line hits, R2 both halves
      do_fetch(16'h0040, "R4", 1'b1);
      do_fetch(16'h0060, "R2", 1'b1);

      // R7 replacement order in set 0
      do_fetch(16'h0100, "R7", 1'b1);
      wait_idle();
      do_fetch(16'h0000, "R7", 1'b1);
      do_fetch(16'h0200, "R7", 1'b1);
      wait_idle();
      do_fetch(16'h0000, "R7", 1'b1);
      do_fetch(16'h0100, "R7", 1'b1);
      wait_idle();

      // R8 flush forces a refill
      do_flush();
      do_fetch(16'h0000, "R8", 1'b1);
      wait_idle();

      // R4 prefetch skipped when the next line is resident
      do_flush();
      do_fetch(16'h0080, "R4", 1'b1);
      wait_idle();
      do_fetch(16'h0040, "R4", 1'b1);
      wait_idle();
      do_fetch(16'h00A0, "R4", 1'b1);

      // R5 top line: no prefetch past the end
      do_fetch(16'hFFE0, "R5", 1'b1);
      wait_idle();
      do_fetch(16'hFFC0, "R5", 1'b1);

      // R6 miss queued behind a prefetch
      do_fetch(16'h1000, "R6", 1'b1);
      do_fetch(16'h2000, "R6", 1'b1);
      wait_idle();
      do_fetch(16'h2020, "R6", 1'b1);
      // R6 miss inside the line being prefetched: no extra request
      do_fetch(16'h3000, "R6", 1'b1);
      do_fetch(16'h3040, "R6", 1'b0);
      wait_idle();
      // R10 refetching resident lines stays single-copy and correct
      do_fetch(16'h3060, "R10", 1'b1);
      do_fetch(16'h3020, "R10", 1'b1);

      wait_idle();
      check(rsp_seen == n_fetch, "R2", "one response per fetch", HALF_W'(rsp_seen), HALF_W'(n_fetch));
      check(exp_q.size() == 0, "R4", "expected fills not requested", HALF_W'(exp_q.size()), '0);
      finish_run();
   end

endmodule